// File: doc/BRIEF.md
# Monitor Configuration and Reset Controller

This block owns the control register of a system hardware monitor and decides when the monitor's register set goes back to its initial state. A host reads and writes an 8-bit register file over a simple single-cycle bus. The control register drives several outputs:

- the run/shutdown signal for the measurement loop;
- the enables for the two interrupt outputs;
- the polarity of the second interrupt;
- an interrupt clear;
- an active-low power-bypass line.

The register file also holds:

- two sticky interrupt status registers fed by event inputs;
- two pairs of interrupt mask registers;
- a fan-divisor register;
- a serial bus address register;
- an identification register;
- a small store for conversion results and limits.

Resets come in two tiers. A soft initialization is requested by writing a self-clearing bit of the control register. It returns every control, status and mask register to its default, but it leaves the serial bus address alone. A full reset is equivalent to power-on and also restores the serial bus address. It is requested in one of two ways:

- by writing a trigger bit of the identification register;
- by a pin pattern in which the raw read and write strobes are both low while chip select is inactive (high) for a parameterized number of consecutive synchronized clock cycles.

Neither tier touches the result and limit store. Each tier is announced on its own one-cycle pulse output, so that other monitor logic can follow it.

Top module: `moncfg_ctrl`

## Requirements
- R1: After the reset input the control register reads 0x08, so that only the interrupt clear (bit 3) is set. Run, both enables and the polarity output are 0, and the bypass output is 1. The status registers read 0x00 and the four mask registers read 0xFF. The fan divisor reads 0x50 and the serial address reads 0x2D. The identification register (address 0x01) reads 0x40 | CHIP_REV.
- R2: The control register is at address 0x00. Bit 0 drives run, bit 1 the first interrupt enable and bit 2 the second interrupt enable. Bit 3 drives the interrupt clear and bit 5 the active-high polarity of the second interrupt. Setting bit 6 drives the bypass output low. Each output follows in the cycle after the write edge. Bits 4 and 7 always read 0.
- R3: Writing 1 to control bit 7 raises soft_init_o for exactly one cycle, the cycle after the write edge. At the next edge, the control, status, mask and fan-divisor registers return to their R1 values.
- R4: A soft initialization leaves the serial address register (0x09) unchanged.
- R5: Neither reset tier changes the result and limit store at addresses 0x10 to 0x1F.
- R6: Writing 1 to bit 5 of the identification register raises full_rst_o for one cycle, the cycle after the write edge. At the next edge, every register, including the serial address, returns to its R1 value. Bit 5 reads back as 0 and bit 6 reads back as 1.
- R7: strb_rd_n and strb_wr_n held low together with strb_cs_n high for STRAP_CYCLES consecutive clock edges cause exactly one full reset. A hold that is one edge shorter causes none.
- R8: The strobe pattern causes no reset while strb_cs_n is low.
- R9: Status bits (0x02, 0x03) are set by a high event input bit and stay set. A write of 1 clears a bit. An event in the same cycle wins over the clear.
- R10: All registers can be written and read while the run bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| strb_rd_n | input | 1 | Raw read strobe pin, active low |
| strb_wr_n | input | 1 | Raw write strobe pin, active low |
| strb_cs_n | input | 1 | Raw chip select pin, active low |
| stat1_evt | input | 8 | Event bits for status register 1 |
| stat2_evt | input | 8 | Event bits for status register 2 |
| mon_run_o | output | 1 | Measurement loop running (0 = shutdown) |
| smi_en_o | output | 1 | First interrupt output enable |
| nmi_en_o | output | 1 | Second interrupt output enable |
| nmi_active_high_o | output | 1 | Second interrupt polarity, 1 = active high |
| int_clear_o | output | 1 | Forces both interrupt outputs inactive |
| pwr_bypass_n_o | output | 1 | Power-bypass drive, active low |
| soft_init_o | output | 1 | One-cycle soft initialization pulse |
| full_rst_o | output | 1 | One-cycle full reset pulse |

## Verification
Read data is combinational, so the scoreboard monitor compares it on the falling edge inside the access cycle. Control outputs and both reset pulses are due in the cycle after the write edge, and the bench samples them on the falling edge that follows. Registers reach their defaults one edge later, and the bus tasks always leave an idle cycle, so the next read already sees them. For the strobe pattern, full_rst_o rises SYNC_STAGES + STRAP_CYCLES edges after the pins go low. The bench therefore waits a fixed margin and then judges the outcome through a pulse counter and a readback of the serial address.

// File: rtl/moncfg_pkg.sv
package moncfg_pkg;

    // Control register layout; bit positions are decoded by the rest of the monitor
    typedef struct packed {
        logic init;      // 7: soft initialization trigger, self-clearing
        logic pwr_byp;   // 6: power bypass
        logic nmi_hi;    // 5: second interrupt active high
        logic rsv;       // 4: reserved
        logic int_clr;   // 3: interrupt clear
        logic nmi_en;    // 2: second interrupt enable
        logic smi_en;    // 1: first interrupt enable
        logic start;     // 0: run measurement loop
    } cfg_t;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_SOFT = 2'd1,
        RK_FULL = 2'd2
    } rst_kind_e;

    localparam int ADR_CFG    = 'h00;
    localparam int ADR_CHIPID = 'h01;
    localparam int ADR_STAT1  = 'h02;
    localparam int ADR_STAT2  = 'h03;
    localparam int ADR_SMIM1  = 'h04;
    localparam int ADR_SMIM2  = 'h05;
    localparam int ADR_NMIM1  = 'h06;
    localparam int ADR_NMIM2  = 'h07;
    localparam int ADR_FANDIV = 'h08;
    localparam int ADR_SBADDR = 'h09;

    localparam logic [7:0] CFG_RST    = 8'h08;
    localparam logic [7:0] STAT_RST   = 8'h00;
    localparam logic [7:0] MASK_RST   = 8'hFF;
    localparam logic [7:0] FANDIV_RST = 8'h50;
    localparam logic [7:0] SBADDR_RST = 8'h2D;

    localparam int CHIPID_FULL_BIT = 5;
    localparam int CHIPID_TAG_BIT  = 6;

    // Trigger and reserved bits are never stored
    function automatic cfg_t cfg_store(input logic [7:0] d);
        cfg_t c;
        c      = cfg_t'(d);
        c.init = 1'b0;
        c.rsv  = 1'b0;
        return c;
    endfunction

    function automatic logic [7:0] chipid_word(input logic [3:0] rev);
        logic [7:0] w;
        w                 = {4'h0, rev};
        w[CHIPID_TAG_BIT] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/moncfg_strap_detect.sv
module moncfg_strap_detect #(
    parameter int SYNC_STAGES  = 2,
    parameter int STRAP_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_n_pin,
    input  logic wr_n_pin,
    input  logic cs_n_pin,
    output logic hit
);
    localparam int CNT_W = $clog2(STRAP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRAP_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(STRAP_CYCLES);

    logic [SYNC_STAGES-1:0] rd_sh, wr_sh, cs_sh;
    logic [CNT_W-1:0]       cnt;
    logic                   pattern;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sh <= '1;
            wr_sh <= '1;
            cs_sh <= '0;
        end else begin
            rd_sh <= {rd_sh[SYNC_STAGES-2:0], rd_n_pin};
            wr_sh <= {wr_sh[SYNC_STAGES-2:0], wr_n_pin};
            cs_sh <= {cs_sh[SYNC_STAGES-2:0], cs_n_pin};
        end
    end

    assign pattern = !rd_sh[SYNC_STAGES-1] && !wr_sh[SYNC_STAGES-1] && cs_sh[SYNC_STAGES-1];

    // Counter saturates so one continuous hold fires only once
    always_ff @(posedge clk) begin
        if (rst || !pattern) begin
            cnt <= '0;
        end else if (cnt != CNT_SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = pattern && (cnt == CNT_LAST);

endmodule

// File: rtl/moncfg_reset_seq.sv
module moncfg_reset_seq
    import moncfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      soft_req,
    input  logic      full_wr_req,
    input  logic      strap_hit,
    output logic      soft_pulse,
    output logic      full_pulse,
    output rst_kind_e kind
);
    logic full_req;

    assign full_req = full_wr_req || strap_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_pulse <= 1'b0;
            full_pulse <= 1'b0;
        end else begin
            full_pulse <= full_req;
            soft_pulse <= soft_req && !full_req;
        end
    end

    always_comb begin
        if (full_pulse)      kind = RK_FULL;
        else if (soft_pulse) kind = RK_SOFT;
        else                 kind = RK_NONE;
    end

endmodule

// File: rtl/moncfg_regfile.sv
module moncfg_regfile
    import moncfg_pkg::*;
#(
    parameter int         ADDR_W    = 6,
    parameter int         VAL_DEPTH = 16,
    parameter int         VAL_BASE  = 16,
    parameter logic [3:0] CHIP_REV  = 4'h3
) (
    input  logic              clk,
    input  logic              rst,
    input  rst_kind_e         kind,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    input  logic [7:0]        evt1,
    input  logic [7:0]        evt2,
    output cfg_t              cfg,
    output logic              soft_req,
    output logic              full_wr_req
);
    localparam int VAL_AW  = $clog2(VAL_DEPTH);
    localparam int BANKS   = 2;
    localparam int PAGE_W  = ADDR_W - VAL_AW;
    localparam logic [PAGE_W-1:0] VAL_PAGE = PAGE_W'(VAL_BASE >> VAL_AW);

    logic [7:0] stat_q [BANKS];
    logic [7:0] smim_q [BANKS];
    logic [7:0] nmim_q [BANKS];
    logic [7:0] evt    [BANKS];
    logic [7:0] fandiv_q, sbaddr_q;
    logic [7:0] val_mem [VAL_DEPTH];
    logic       wr, val_hit;
    logic       wr_stat [BANKS];
    logic       wr_smim [BANKS];
    logic       wr_nmim [BANKS];
    logic       soft_clr, full_clr;

    assign evt[0]   = evt1;
    assign evt[1]   = evt2;
    assign wr       = acc_en && acc_we;
    assign val_hit  = acc_addr[ADDR_W-1:VAL_AW] == VAL_PAGE;
    assign full_clr = rst || (kind == RK_FULL);
    assign soft_clr = full_clr || (kind == RK_SOFT);

    assign soft_req    = wr && (acc_addr == ADDR_W'(ADR_CFG)) && acc_wdata[7];
    assign full_wr_req = wr && (acc_addr == ADDR_W'(ADR_CHIPID)) && acc_wdata[CHIPID_FULL_BIT];

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            assign wr_stat[b] = wr && (acc_addr == ADDR_W'(ADR_STAT1 + b));
            assign wr_smim[b] = wr && (acc_addr == ADDR_W'(ADR_SMIM1 + b));
            assign wr_nmim[b] = wr && (acc_addr == ADDR_W'(ADR_NMIM1 + b));

            always_ff @(posedge clk) begin
                if (soft_clr) begin
                    stat_q[b] <= STAT_RST;
                    smim_q[b] <= MASK_RST;
                    nmim_q[b] <= MASK_RST;
                end else begin
                    // write-one-to-clear, a new event wins
                    stat_q[b] <= (stat_q[b] & ~(wr_stat[b] ? acc_wdata : 8'h00)) | evt[b];
                    if (wr_smim[b]) smim_q[b] <= acc_wdata;
                    if (wr_nmim[b]) nmim_q[b] <= acc_wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (soft_clr) begin
            cfg      <= cfg_t'(CFG_RST);
            fandiv_q <= FANDIV_RST;
        end else begin
            if (wr && acc_addr == ADDR_W'(ADR_CFG))    cfg      <= cfg_store(acc_wdata);
            if (wr && acc_addr == ADDR_W'(ADR_FANDIV)) fandiv_q <= acc_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (full_clr) begin
            sbaddr_q <= SBADDR_RST;
        end else if (wr && acc_addr == ADDR_W'(ADR_SBADDR)) begin
            sbaddr_q <= acc_wdata;
        end
    end

    // Results and limits: untouched by either reset tier
    always_ff @(posedge clk) begin
        if (wr && val_hit) val_mem[acc_addr[VAL_AW-1:0]] <= acc_wdata;
    end

    always_comb begin
        acc_rdata = 8'h00;
        if (val_hit) begin
            acc_rdata = val_mem[acc_addr[VAL_AW-1:0]];
        end else begin
            case (acc_addr)
                ADDR_W'(ADR_CFG):    acc_rdata = cfg;
                ADDR_W'(ADR_CHIPID): acc_rdata = chipid_word(CHIP_REV);
                ADDR_W'(ADR_STAT1):  acc_rdata = stat_q[0];
                ADDR_W'(ADR_STAT2):  acc_rdata = stat_q[1];
                ADDR_W'(ADR_SMIM1):  acc_rdata = smim_q[0];
                ADDR_W'(ADR_SMIM2):  acc_rdata = smim_q[1];
                ADDR_W'(ADR_NMIM1):  acc_rdata = nmim_q[0];
                ADDR_W'(ADR_NMIM2):  acc_rdata = nmim_q[1];
                ADDR_W'(ADR_FANDIV): acc_rdata = fandiv_q;
                ADDR_W'(ADR_SBADDR): acc_rdata = sbaddr_q;
                default:             acc_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/moncfg_ctrl.sv
module moncfg_ctrl
    import moncfg_pkg::*;
#(
    parameter int         ADDR_W       = 6,
    parameter int         VAL_DEPTH    = 16,
    parameter int         VAL_BASE     = 16,
    parameter int         SYNC_STAGES  = 2,
    parameter int         STRAP_CYCLES = 10,
    parameter logic [3:0] CHIP_REV     = 4'h3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              strb_rd_n,
    input  logic              strb_wr_n,
    input  logic              strb_cs_n,
    input  logic [7:0]        stat1_evt,
    input  logic [7:0]        stat2_evt,
    output logic              mon_run_o,
    output logic              smi_en_o,
    output logic              nmi_en_o,
    output logic              nmi_active_high_o,
    output logic              int_clear_o,
    output logic              pwr_bypass_n_o,
    output logic              soft_init_o,
    output logic              full_rst_o
);
    cfg_t      cfg;
    rst_kind_e kind;
    logic      soft_req, full_wr_req, strap_hit;

    moncfg_strap_detect #(
        .SYNC_STAGES (SYNC_STAGES),
        .STRAP_CYCLES(STRAP_CYCLES)
    ) u_strap (
        .clk     (clk),
        .rst     (rst),
        .rd_n_pin(strb_rd_n),
        .wr_n_pin(strb_wr_n),
        .cs_n_pin(strb_cs_n),
        .hit     (strap_hit)
    );

    moncfg_reset_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .soft_req   (soft_req),
        .full_wr_req(full_wr_req),
        .strap_hit  (strap_hit),
        .soft_pulse (soft_init_o),
        .full_pulse (full_rst_o),
        .kind       (kind)
    );

    moncfg_regfile #(
        .ADDR_W   (ADDR_W),
        .VAL_DEPTH(VAL_DEPTH),
        .VAL_BASE (VAL_BASE),
        .CHIP_REV (CHIP_REV)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .acc_en     (bus_en),
        .acc_we     (bus_we),
        .acc_addr   (bus_addr),
        .acc_wdata  (bus_wdata),
        .acc_rdata  (bus_rdata),
        .evt1       (stat1_evt),
        .evt2       (stat2_evt),
        .cfg        (cfg),
        .soft_req   (soft_req),
        .full_wr_req(full_wr_req)
    );

    assign mon_run_o         = cfg.start;
    assign smi_en_o          = cfg.smi_en;
    assign nmi_en_o          = cfg.nmi_en;
    assign nmi_active_high_o = cfg.nmi_hi;
    assign int_clear_o       = cfg.int_clr;
    assign pwr_bypass_n_o    = !cfg.pwr_byp;

endmodule

// File: rtl/moncfg_ctrl_chk.sv
module moncfg_ctrl_chk
    import moncfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              mon_run_o,
    input logic              smi_en_o,
    input logic              nmi_en_o,
    input logic              nmi_active_high_o,
    input logic              int_clear_o,
    input logic              pwr_bypass_n_o,
    input logic              soft_init_o,
    input logic              full_rst_o
);
    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (int_clear_o && !mon_run_o && !smi_en_o && !nmi_en_o
                        && !nmi_active_high_o && pwr_bypass_n_o)); // R1

    AST_SOFT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        soft_init_o |-> $past(bus_en && bus_we && bus_addr == ADDR_W'(ADR_CFG) && bus_wdata[7])); // R3

    AST_TIERS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(soft_init_o && full_rst_o)); // R3

    AST_CFG_AFTER_TIER: assert property (@(posedge clk) disable iff (rst)
        (soft_init_o || full_rst_o) |=> (int_clear_o && !mon_run_o && !smi_en_o && !nmi_en_o
                                         && !nmi_active_high_o && pwr_bypass_n_o)); // R6

endmodule

bind moncfg_ctrl moncfg_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_en           (bus_en),
    .bus_we           (bus_we),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .mon_run_o        (mon_run_o),
    .smi_en_o         (smi_en_o),
    .nmi_en_o         (nmi_en_o),
    .nmi_active_high_o(nmi_active_high_o),
    .int_clear_o      (int_clear_o),
    .pwr_bypass_n_o   (pwr_bypass_n_o),
    .soft_init_o      (soft_init_o),
    .full_rst_o       (full_rst_o)
);

// File: tb/tb_moncfg_ctrl.sv
`timescale 1ns/1ps
module tb_moncfg_ctrl;
    localparam int ADDR_W = 6;
    localparam int STRAP  = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_en = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0, bus_rdata;
    logic              strb_rd_n = 1'b1, strb_wr_n = 1'b1, strb_cs_n = 1'b1;
    logic [7:0]        stat1_evt = '0, stat2_evt = '0;
    logic mon_run_o, smi_en_o, nmi_en_o, nmi_active_high_o, int_clear_o, pwr_bypass_n_o;
    logic soft_init_o, full_rst_o;

    int checks = 0, fails = 0, soft_cnt = 0, full_cnt = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #2.5 clk = ~clk;

    moncfg_ctrl #(.ADDR_W(ADDR_W), .STRAP_CYCLES(STRAP)) dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .strb_rd_n(strb_rd_n),
        .strb_wr_n(strb_wr_n), .strb_cs_n(strb_cs_n), .stat1_evt(stat1_evt),
        .stat2_evt(stat2_evt), .mon_run_o(mon_run_o), .smi_en_o(smi_en_o),
        .nmi_en_o(nmi_en_o), .nmi_active_high_o(nmi_active_high_o),
        .int_clear_o(int_clear_o), .pwr_bypass_n_o(pwr_bypass_n_o),
        .soft_init_o(soft_init_o), .full_rst_o(full_rst_o));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // {run, smi, nmi, clr, nmi_hi, bypass_n}
    function automatic logic [7:0] outs();
        return {2'b00, mon_run_o, smi_en_o, nmi_en_o, int_clear_o, nmi_active_high_o, pwr_bypass_n_o};
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_en = 1; bus_we = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 0; bus_we = 0;
    endtask

    // driver: push the expected value, monitor compares in the access cycle
    task automatic rd(input int a, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        exp_q.push_back(exp); req_q.push_back(req);
        bus_en = 1; bus_we = 0; bus_addr = ADDR_W'(a);
        @(posedge clk); #1;
        bus_en = 0;
    endtask

    task automatic strap(input int edges, input logic cs_n);
        @(posedge clk); #1;
        strb_rd_n = 0; strb_wr_n = 0; strb_cs_n = cs_n;
        repeat (edges) @(posedge clk);
        #1;
        strb_rd_n = 1; strb_wr_n = 1; strb_cs_n = 1;
    endtask

    always @(negedge clk) begin
        if (soft_init_o) soft_cnt++;
        if (full_rst_o)  full_cnt++;
        if (bus_en && !bus_we) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard", bus_rdata, 8'hxx);
            end else begin
                chk(req_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", outs(), 8'h05);
        chk("R1 pulses", {6'd0, soft_init_o, full_rst_o}, 8'h00);
        rd('h00, 8'h08, "R1 cfg");
        rd('h01, 8'h43, "R1 chipid");
        rd('h02, 8'h00, "R1 stat1");
        rd('h03, 8'h00, "R1 stat2");
        rd('h04, 8'hFF, "R1 smim1");
        rd('h07, 8'hFF, "R1 nmim2");
        rd('h08, 8'h50, "R1 fandiv");
        rd('h09, 8'h2D, "R1 sbaddr");

        // R2 control bits
        wr('h00, 8'h67);
        @(negedge clk);
        chk("R2 outputs 0x67", outs(), 8'h3A);
        rd('h00, 8'h67, "R2 cfg readback");
        wr('h00, 8'h18);
        @(negedge clk);
        chk("R2 outputs 0x18", outs(), 8'h05);
        rd('h00, 8'h08, "R2 bit4 reads 0");

        // R10 access in shutdown
        wr('h04, 8'h12); wr('h05, 8'h34); wr('h06, 8'h56); wr('h07, 8'h78);
        wr('h08, 8'h9A); wr('h09, 8'h11); wr('h10, 8'hA5); wr('h1F, 8'h3C);
        chk("R10 run low", {7'd0, mon_run_o}, 8'h00);
        rd('h04, 8'h12, "R10 smim1"); rd('h05, 8'h34, "R10 smim2");
        rd('h06, 8'h56, "R10 nmim1"); rd('h07, 8'h78, "R10 nmim2");
        rd('h08, 8'h9A, "R10 fandiv"); rd('h09, 8'h11, "R10 sbaddr");
        rd('h10, 8'hA5, "R10 val0"); rd('h1F, 8'h3C, "R10 val15");

        // R9 sticky status
        @(posedge clk); #1 stat1_evt = 8'h05; stat2_evt = 8'h80;
        @(posedge clk); #1 stat1_evt = 8'h00; stat2_evt = 8'h00;
        rd('h02, 8'h05, "R9 stat1 set");
        rd('h03, 8'h80, "R9 stat2 set");
        wr('h02, 8'h01);
        rd('h02, 8'h04, "R9 w1c");
        stat1_evt = 8'h04;
        wr('h02, 8'h04);
        stat1_evt = 8'h00;
        rd('h02, 8'h04, "R9 event wins");

        // R3 soft init, R4, R5
        wr('h00, 8'h67);
        base = soft_cnt;
        wr('h00, 8'h81);
        @(negedge clk);
        chk("R3 soft pulse", {6'd0, soft_init_o, full_rst_o}, 8'h02);
        @(negedge clk);
        chk("R3 pulse one cycle", 8'(soft_cnt - base), 8'h01);
        chk("R3 outputs default", outs(), 8'h05);
        rd('h00, 8'h08, "R3 cfg");
        rd('h02, 8'h00, "R3 stat1");
        rd('h03, 8'h00, "R3 stat2");
        rd('h05, 8'hFF, "R3 smim2");
        rd('h06, 8'hFF, "R3 nmim1");
        rd('h08, 8'h50, "R3 fandiv");
        rd('h09, 8'h11, "R4 sbaddr kept");
        rd('h10, 8'hA5, "R5 val0 soft");
        rd('h1F, 8'h3C, "R5 val15 soft");

        // R6 full reset through register
        wr('h00, 8'h41);
        base = full_cnt;
        wr('h01, 8'h20);
        @(negedge clk);
        chk("R6 full pulse", {6'd0, soft_init_o, full_rst_o}, 8'h01);
        @(negedge clk);
        chk("R6 pulse one cycle", 8'(full_cnt - base), 8'h01);
        chk("R6 outputs default", outs(), 8'h05);
        rd('h09, 8'h2D, "R6 sbaddr");
        rd('h01, 8'h43, "R6 chipid");
        rd('h10, 8'hA5, "R5 val0 full");

        // R7 strobe pattern
        wr('h09, 8'h22);
        base = full_cnt;
        strap(STRAP - 1, 1'b1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R7 short hold", 8'(full_cnt - base), 8'h00);
        rd('h09, 8'h22, "R7 short keeps sbaddr");
        strap(STRAP + 15, 1'b1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R7 long hold one pulse", 8'(full_cnt - base), 8'h01);
        rd('h09, 8'h2D, "R7 sbaddr reset");

        // R8 chip select active blocks pattern
        wr('h09, 8'h22);
        base = full_cnt;
        strap(STRAP + 15, 1'b0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R8 no pulse", 8'(full_cnt - base), 8'h00);
        rd('h09, 8'h22, "R8 sbaddr kept");

        repeat (3) @(posedge clk);
        chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule